// File: doc/BRIEF.md
# Programmable Burst DMA Request Controller

This block manages the request/acknowledge handshake between a node's buffer memory and an external DMA engine. It raises a request line toward the DMA engine, watches the acknowledge, the per-cycle read/write strobe and the terminal-count pin, and passes each accepted transfer cycle to the memory port as a single strobe. The bus cycle timing itself is not generated here.

Three transfer styles are offered. In the single style the request is given up after every cycle. In the burst style it is held until the transfer ends. In the programmable-burst style it is given up periodically, either after a programmable number of clocks or after a programmable number of transfer cycles, so that a memory refresh can get onto the bus. A falling edge on the refresh-execution input cuts the current programmable burst short. The transfer ends either on the external terminal-count pin or on an internal transfer counter. At the end the busy bit clears itself and an end-of-transfer flag is set, which raises the interrupt unless masked.

Top module: `dreq_burst_ctrl`

## Requirements
- R1: After reset `dma_busy` and `irq` are 0 and `dma_req` sits at its inactive level.
- R2: `dma_req` is driven at level `cfg_dreq_pol` while requesting and at the opposite level otherwise (1 = active high).
- R3: With `cfg_mode` = 2'b01 (burst) the request, once raised, stays active until the transfer ends.
- R4: With `cfg_mode` = 2'b00 or 2'b11 (single) the request drops after each accepted transfer cycle.
- R5: A `start` pulse is followed by at least one clock with `dack_n` high before the first request; the request is never raised while `dack_n` is low, and it returns the clock after `dack_n` is seen high.
- R6: With `cfg_mode` = 2'b10 and `cfg_gate_by_cyc` = 1, each burst carries `cfg_gate_val` transfer cycles (0 means 2^GATE_W).
- R7: With `cfg_mode` = 2'b10 and `cfg_gate_by_cyc` = 0, each burst holds the request for `cfg_gate_val` clocks (0 means 2^GATE_W).
- R8: With `cfg_int_term` = 1 the transfer ends on the `cfg_xfer_total`-th accepted cycle (0 means 2^CNT_W), and `tc_pin` has no effect.
- R9: With `cfg_int_term` = 0 the transfer ends on the accepted cycle during which `tc_pin` equals `cfg_tc_pol` (1 = active high).
- R10: In programmable-burst mode a falling edge on `refex_n` during a request ends the current burst after that clock; in the other modes it has no effect.
- R11: When the transfer ends `dma_busy` clears and the end flag sets; `irq` is the flag gated by `~cfg_irq_mask`; a `start` pulse clears the flag.
- R12: `ram_stb` pulses once for each accepted transfer cycle (strobe high, acknowledge low, request active).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | 00/11 single, 01 burst, 10 programmable burst |
| cfg_gate_by_cyc | input | 1 | Programmable burst gate: 1 cycle count, 0 clock timer |
| cfg_gate_val | input | GATE_W | Gate length, 0 means 2^GATE_W |
| cfg_int_term | input | 1 | 1 end on internal count, 0 end on terminal-count pin |
| cfg_xfer_total | input | CNT_W | Transfer cycles for internal termination, 0 means 2^CNT_W |
| cfg_dreq_pol | input | 1 | Active level of `dma_req` |
| cfg_tc_pol | input | 1 | Active level of `tc_pin` |
| cfg_irq_mask | input | 1 | 1 masks the end-of-transfer interrupt |
| start | input | 1 | One-clock pulse that arms a transfer (ignored while busy) |
| dma_req | output | 1 | Request to the DMA engine |
| dack_n | input | 1 | Acknowledge from the DMA engine, active low |
| xfer_stb | input | 1 | Read/write cycle strobe, one clock per cycle |
| tc_pin | input | 1 | External terminal count |
| refex_n | input | 1 | Refresh execution, falling edge detected |
| ram_stb | output | 1 | Accepted transfer cycle toward the memory port |
| dma_busy | output | 1 | Transfer armed and not yet ended |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
The bench builds the block with GATE_W = 8 and CNT_W = 16, so a gate value of zero means 256 and transfers of 300 cycles are enough to cross that wrap in both cycle-gated and timer-gated bursts. A modelled DMA engine answers requests and counts transfers and bursts, which are compared with counts derived from the gate and termination settings. Both polarities of the request and terminal-count pins, a held-low acknowledge and a refresh edge inside and outside programmable bursts are covered.

// File: rtl/drq_pkg.sv
package drq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_REQ  = 2'd2
    } drq_state_e;

    localparam logic [1:0] MODE_SINGLE = 2'b00;
    localparam logic [1:0] MODE_BURST  = 2'b01;
    localparam logic [1:0] MODE_PROG   = 2'b10;

    typedef struct packed {
        drq_state_e st;
        logic       busy;
        logic       flag;
    } drq_ctl_t;

endpackage

// File: rtl/drq_down_ctr.sv
module drq_down_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    localparam logic [W:0] FULL = {1'b1, {W{1'b0}}};
    localparam logic [W:0] ONE  = {{W{1'b0}}, 1'b1};

    logic [W:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = (load_val == '0) ? FULL : {1'b0, load_val};
        end else if (dec && cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == ONE);
endmodule

// File: rtl/drq_fall_det.sv
module drq_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_n,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign fall = prev_q & ~sig_n;
endmodule

// File: rtl/dreq_burst_ctrl.sv
module dreq_burst_ctrl
    import drq_pkg::*;
#(
    parameter int GATE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_gate_by_cyc,
    input  logic [GATE_W-1:0] cfg_gate_val,
    input  logic              cfg_int_term,
    input  logic [CNT_W-1:0]  cfg_xfer_total,
    input  logic              cfg_dreq_pol,
    input  logic              cfg_tc_pol,
    input  logic              cfg_irq_mask,
    input  logic              start,
    output logic              dma_req,
    input  logic              dack_n,
    input  logic              xfer_stb,
    input  logic              tc_pin,
    input  logic              refex_n,
    output logic              ram_stb,
    output logic              dma_busy,
    output logic              irq
);
    drq_ctl_t ctl_d, ctl_q;

    logic act;
    logic xfer;
    logic tc_hit;
    logic term;
    logic single_md;
    logic prog_md;
    logic gate_end;
    logic release_req;
    logic refr_fall;
    logic gate_last;
    logic tot_last;
    logic gate_load;
    logic gate_dec;
    logic tot_load;

    drq_fall_det u_refr (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_n (refex_n),
        .fall  (refr_fall)
    );

    drq_down_ctr #(.W(GATE_W)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gate_load),
        .load_val (cfg_gate_val),
        .dec      (gate_dec),
        .last     (gate_last)
    );

    drq_down_ctr #(.W(CNT_W)) u_total (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tot_load),
        .load_val (cfg_xfer_total),
        .dec      (xfer),
        .last     (tot_last)
    );

    always_comb begin
        act       = (ctl_q.st == ST_REQ);
        xfer      = act & xfer_stb & ~dack_n;
        tc_hit    = (tc_pin == cfg_tc_pol);
        term      = xfer & (cfg_int_term ? tot_last : tc_hit);
        single_md = (cfg_mode[1] == cfg_mode[0]);
        prog_md   = (cfg_mode == MODE_PROG);
        gate_end  = prog_md & act & gate_last & (cfg_gate_by_cyc ? xfer : 1'b1);
        release_req = (single_md & xfer) | gate_end | (prog_md & act & refr_fall);

        gate_load = (ctl_q.st == ST_WAIT) & dack_n;
        gate_dec  = act & (cfg_gate_by_cyc ? xfer : 1'b1);
        tot_load  = (ctl_q.st == ST_IDLE) & start;

        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st   = ST_WAIT;
                    ctl_d.busy = 1'b1;
                    ctl_d.flag = 1'b0;
                end
            end
            ST_WAIT: begin
                if (dack_n) ctl_d.st = ST_REQ;
            end
            ST_REQ: begin
                if (term) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.busy = 1'b0;
                    ctl_d.flag = 1'b1;
                end else if (release_req) begin
                    ctl_d.st = ST_WAIT;
                end
            end
            default: begin
                ctl_d.st   = ST_IDLE;
                ctl_d.busy = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, busy: 1'b0, flag: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign dma_req  = ~(act ^ cfg_dreq_pol);
    assign ram_stb  = xfer;
    assign dma_busy = ctl_q.busy;
    assign irq      = ctl_q.flag & ~cfg_irq_mask;
endmodule

// File: rtl/dreq_burst_ctrl_chk.sv
module dreq_burst_ctrl_chk
    import drq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic       cfg_dreq_pol,
    input logic       cfg_irq_mask,
    input logic       dma_req,
    input logic       dack_n,
    input logic       ram_stb,
    input logic       dma_busy,
    input logic       irq
);
    logic req_on;
    assign req_on = (dma_req == cfg_dreq_pol);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_busy |-> !req_on); // R1

    AST_NO_REQ_UNDER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_on && !dack_n) |=> !req_on); // R5

    AST_START_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_busy) |-> !req_on); // R5

    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_on && cfg_mode == MODE_BURST && !ram_stb) |=> req_on); // R3

    AST_SINGLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode[1] == cfg_mode[0] && ram_stb) |=> !req_on); // R4

    AST_END_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dma_busy) && !cfg_irq_mask) |-> irq); // R11
endmodule

bind dreq_burst_ctrl dreq_burst_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_mode     (cfg_mode),
    .cfg_dreq_pol (cfg_dreq_pol),
    .cfg_irq_mask (cfg_irq_mask),
    .dma_req      (dma_req),
    .dack_n       (dack_n),
    .ram_stb      (ram_stb),
    .dma_busy     (dma_busy),
    .irq          (irq)
);

// File: tb/tb_dreq_burst_ctrl.sv
module tb_dreq_burst_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int GATE_W = 8;
    localparam int CNT_W  = 16;

    typedef struct packed {
        logic [1:0]  mode;
        logic        cyc;
        logic        intt;
        logic        dpol;
        logic        tpol;
        logic        mask;
        logic [7:0]  gate;
        logic [15:0] total;
        logic [15:0] tc_at;
        logic [15:0] refr;
        logic [15:0] exp_xf;
        logic [15:0] exp_bu;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0, 16'd5,   16'd0, 16'd0, 16'd5,   16'd5},
        '{2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0, 16'd3,   16'd0, 16'd0, 16'd3,   16'd3},
        '{2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0, 16'd7,   16'd0, 16'd0, 16'd7,   16'd1},
        '{2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 16'd100, 16'd6, 16'd0, 16'd6,   16'd1},
        '{2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0, 16'd100, 16'd4, 16'd0, 16'd4,   16'd1},
        '{2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0, 16'd5,   16'd2, 16'd0, 16'd5,   16'd1},
        '{2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'd3, 16'd10,  16'd0, 16'd0, 16'd10,  16'd4},
        '{2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0, 16'd300, 16'd0, 16'd0, 16'd300, 16'd2},
        '{2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd4, 16'd9,   16'd0, 16'd0, 16'd9,   16'd3},
        '{2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0, 16'd300, 16'd0, 16'd0, 16'd300, 16'd2},
        '{2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd0, 16'd4,   16'd0, 16'd0, 16'd4,   16'd1},
        '{2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd2, 16'd100, 16'd5, 16'd0, 16'd5,   16'd3},
        '{2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0, 16'd10,  16'd0, 16'd3, 16'd10,  16'd2},
        '{2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0, 16'd10,  16'd0, 16'd3, 16'd10,  16'd1},
        '{2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd0, 16'd2,   16'd0, 16'd0, 16'd2,   16'd1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_mode = 2'b00;
    logic              cfg_gate_by_cyc = 1'b0;
    logic [GATE_W-1:0] cfg_gate_val = '0;
    logic              cfg_int_term = 1'b1;
    logic [CNT_W-1:0]  cfg_xfer_total = '0;
    logic              cfg_dreq_pol = 1'b1;
    logic              cfg_tc_pol = 1'b1;
    logic              cfg_irq_mask = 1'b0;
    logic              start = 1'b0;
    logic              dma_req;
    logic              dack_n = 1'b1;
    logic              xfer_stb = 1'b0;
    logic              tc_pin = 1'b0;
    logic              refex_n = 1'b1;
    logic              ram_stb;
    logic              dma_busy;
    logic              irq;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    dreq_burst_ctrl #(.GATE_W(GATE_W), .CNT_W(CNT_W)) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_mode        (cfg_mode),
        .cfg_gate_by_cyc (cfg_gate_by_cyc),
        .cfg_gate_val    (cfg_gate_val),
        .cfg_int_term    (cfg_int_term),
        .cfg_xfer_total  (cfg_xfer_total),
        .cfg_dreq_pol    (cfg_dreq_pol),
        .cfg_tc_pol      (cfg_tc_pol),
        .cfg_irq_mask    (cfg_irq_mask),
        .start           (start),
        .dma_req         (dma_req),
        .dack_n          (dack_n),
        .xfer_stb        (xfer_stb),
        .tc_pin          (tc_pin),
        .refex_n         (refex_n),
        .ram_stb         (ram_stb),
        .dma_busy        (dma_busy),
        .irq             (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string what, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", what, actual, expected);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.refr != 0)       return "R10";
        if (!v.intt)           return "R9";
        if (v.mode == 2'b01)   return v.dpol ? "R3" : "R2";
        if (v.mode == 2'b10)   return v.cyc ? "R6" : "R7";
        return "R4";
    endfunction

    task automatic run_vec(input vec_t v, input int idx);
        int  n, b, rs, guard;
        logic active;
        cfg_mode        = v.mode;
        cfg_gate_by_cyc = v.cyc;
        cfg_gate_val    = v.gate;
        cfg_int_term    = v.intt;
        cfg_xfer_total  = v.total;
        cfg_dreq_pol    = v.dpol;
        cfg_tc_pol      = v.tpol;
        cfg_irq_mask    = v.mask;
        dack_n = 1'b1; xfer_stb = 1'b0; tc_pin = ~v.tpol; refex_n = 1'b1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 0; b = 0; rs = 0; guard = 0;
        while (dma_busy && guard < 5000) begin
            active  = (dma_req == v.dpol);
            refex_n = 1'b1;
            tc_pin  = ~v.tpol;
            if (dack_n) begin
                xfer_stb = 1'b0;
                if (active) begin dack_n = 1'b0; b++; end
            end else if (active) begin
                xfer_stb = 1'b1;
                n++;
                if (n == int'(v.tc_at)) tc_pin = v.tpol;
                if (n == int'(v.refr))  refex_n = 1'b0;
            end else begin
                xfer_stb = 1'b0;
                dack_n   = 1'b1;
            end
            #1;
            if (ram_stb) rs++;
            @(negedge clk);
            guard++;
        end
        xfer_stb = 1'b0; dack_n = 1'b1; tc_pin = ~v.tpol; refex_n = 1'b1;
        check($sformatf("%s transfers vec%0d", v.intt ? "R8" : "R9", idx), n, int'(v.exp_xf));
        check($sformatf("%s bursts vec%0d", tag_of(v), idx), b, int'(v.exp_bu));
        check($sformatf("R12 ram strobes vec%0d", idx), rs, int'(v.exp_xf));
        check($sformatf("R11 busy cleared vec%0d", idx), int'(dma_busy), 0);
        check($sformatf("R11 irq vec%0d", idx), int'(irq), int'(!v.mask));
        check($sformatf("R2 idle level vec%0d", idx), int'(dma_req), int'(!v.dpol));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset dma_req", int'(dma_req), 0);
        check("R1 reset busy", int'(dma_busy), 0);
        check("R1 reset irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_dreq_pol = 1'b0;
        #1;
        check("R2 idle level low-active", int'(dma_req), 1);
        cfg_dreq_pol = 1'b1;
        // refresh edge while idle in single mode must not arm anything
        refex_n = 1'b0;
        @(negedge clk);
        refex_n = 1'b1;
        check("R10 idle refresh no effect", int'(dma_busy), 0);
        // ram strobe outside a request
        xfer_stb = 1'b1; dack_n = 1'b0;
        #1;
        check("R12 no strobe while idle", int'(ram_stb), 0);
        xfer_stb = 1'b0; dack_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], i);
            repeat (2) @(negedge clk);
        end

        // flag held under mask from the last vector, seen once unmasked; start clears it
        cfg_mode = 2'b00; cfg_int_term = 1'b1; cfg_xfer_total = 16'd2;
        cfg_dreq_pol = 1'b1; cfg_irq_mask = 1'b0;
        #1;
        check("R11 flag visible after unmask", int'(irq), 1);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R11 start clears flag", int'(irq), 0);
        check("R5 no request on start clock", int'(dma_req), 0);
        @(negedge clk);
        check("R5 request after dack high", int'(dma_req), 1);
        dack_n = 1'b0; xfer_stb = 1'b1;
        @(negedge clk);
        xfer_stb = 1'b0;
        check("R4 request dropped after cycle", int'(dma_req), 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R5 held off while dack low", int'(dma_req), 0);
        end
        dack_n = 1'b1;
        @(negedge clk);
        check("R5 returns after dack high", int'(dma_req), 1);
        dack_n = 1'b0; xfer_stb = 1'b1;
        @(negedge clk);
        xfer_stb = 1'b0; dack_n = 1'b1;
        check("R8 ends on second cycle", int'(dma_busy), 0);
        check("R11 irq raised", int'(irq), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule